// File: doc/BRIEF.md
# Segmented Multi-Queue Ring Buffer

This block keeps many first-in first-out output queues inside one shared on-chip entry store. Each queue is given a contiguous region made of whole 32-entry segments. Its bounds are a first segment index and a last segment index, both counted inside a 1024-entry block, and a block number that the two bounds share. A region therefore never crosses a block boundary. The low five address bits are never stored in the bounds: an entry address is the concatenation of block number, segment index and offset within the segment.

Producers push an entry by queue number and consumers pop by queue number. Popped data appears one cycle after the pop. For every queue the block keeps a write pointer, a read pointer and an occupancy count. When a pointer steps past the last entry of its last segment, it returns to the first entry of its first segment. The store is split into eight interleaved banks, so that consecutive entries of one queue fall in consecutive banks. Each bank serves one access per cycle. The block reports an empty flag and a full flag for every queue, and it raises a one-cycle error pulse when it drops a request.

Top module: `seg_queue_ring`

## Requirements
- R1: After reset every queue is disabled and empty, no queue is full, and `err` and `pop_rvalid` are low.
- R2: A configuration write stores the first segment from bits [4:0], the last segment from bits [9:5], the block number from bits [14:10] and the enable flag from bit 63. It also returns the queue's read and write pointers to the first entry of its first segment and clears its count, so the queue reads empty in the next cycle.
- R3: Accepted pops return entries in push order. `pop_rvalid` is high, and `pop_rdata` holds the entry, in the cycle after the accepted pop.
- R4: A queue is full when its count equals (last − first + 1) × 32, and empty when its count is zero.
- R5: A pointer that steps past the last entry of the last segment returns to the first entry of the first segment, so data stays in order across any number of wraps. This includes a region in the top segment of the store.
- R6: Three requests are dropped, and `err` is high in the following cycle: a push to a full queue, a push to a disabled queue, and a pop from an empty queue. Acceptance is judged on the queue state before the cycle.
- R7: A push and a pop to the same queue in one cycle are both accepted when they fall in different banks. The count is then unchanged.
- R8: The bank of an entry is entry address bits [2:0]. When an accepted pop and a push fall in the same bank in one cycle, the pop proceeds and the push is dropped with `err`.
- R9: A valid configuration write takes priority over a push or a pop to the same queue in the same cycle. That push or pop is dropped with `err`.
- R10: Queues in different blocks, or in different segments of one block, do not disturb each other's data.
- R11: A configuration write is ignored and raises `err` if any of these holds: its last segment is below its first segment, its block number is not below the number of blocks, or any bit in [62:15] is set. The queue keeps its previous state, and a push or pop in the same cycle proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_qid | input | QW | Queue addressed by the configuration write |
| cfg_wdata | input | 64 | Configuration word |
| push_valid | input | 1 | Push request |
| push_qid | input | QW | Queue to push into |
| push_data | input | DATA_W | Entry to push |
| pop_valid | input | 1 | Pop request |
| pop_qid | input | QW | Queue to pop from |
| pop_rvalid | output | 1 | Popped entry valid (one cycle after the pop) |
| pop_rdata | output | DATA_W | Popped entry |
| q_empty | output | NUM_Q | Per-queue empty flags |
| q_full | output | NUM_Q | Per-queue full flags |
| err | output | 1 | One-cycle pulse for a dropped request or a rejected configuration |

## Verification
A push and a pop can land in the same cycle, either on one queue or on two queues whose current entries share a bank. In that case the block must decide both acceptances together. The bench provokes both cases directly. It holds a queue at a count that is a multiple of eight, so that its read and write pointers share a bank, and at other counts, so that they do not. A long pseudo-random sweep then issues pushes, pops and configuration writes to all queues in the same cycles. A bench model works out each decision from the pointer arithmetic alone, and every cycle is judged on the error pulse, the returned data and the per-queue flags.

// File: rtl/seg_queue_ring.sv
module seg_queue_ring #(
  parameter int NUM_Q   = 8,
  parameter int NUM_BLK = 2,
  parameter int DATA_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [$clog2(NUM_Q)-1:0] cfg_qid,
  input  logic [63:0]              cfg_wdata,
  input  logic                     push_valid,
  input  logic [$clog2(NUM_Q)-1:0] push_qid,
  input  logic [DATA_W-1:0]        push_data,
  input  logic                     pop_valid,
  input  logic [$clog2(NUM_Q)-1:0] pop_qid,
  output logic                     pop_rvalid,
  output logic [DATA_W-1:0]        pop_rdata,
  output logic [NUM_Q-1:0]         q_empty,
  output logic [NUM_Q-1:0]         q_full,
  output logic                     err
);
  localparam int OFF_W  = 5;
  localparam int SEG_W  = 5;
  localparam int LOC_W  = OFF_W + SEG_W;
  localparam int BANKS  = 8;
  localparam int BANK_W = $clog2(BANKS);
  localparam int BLK_W  = $clog2(NUM_BLK);
  localparam int ROW_W  = BLK_W + LOC_W - BANK_W;
  localparam int ROWS   = NUM_BLK * (2 ** LOC_W) / BANKS;
  localparam int CNT_W  = LOC_W + 1;

  logic             q_en    [NUM_Q];
  logic [SEG_W-1:0] q_first [NUM_Q];
  logic [SEG_W-1:0] q_last  [NUM_Q];
  logic [BLK_W-1:0] q_blk   [NUM_Q];
  logic [LOC_W-1:0] rd_ptr  [NUM_Q];
  logic [LOC_W-1:0] wr_ptr  [NUM_Q];
  logic [CNT_W-1:0] occ     [NUM_Q];
  logic [CNT_W-1:0] cap     [NUM_Q];
  logic [LOC_W-1:0] rd_nx   [NUM_Q];
  logic [LOC_W-1:0] wr_nx   [NUM_Q];
  logic [DATA_W-1:0] bank_q [BANKS];

  logic              cfg_ok, cfg_take, push_ok, pop_ok;
  logic [BANK_W-1:0] wr_bank, rd_bank, sel_bank;
  logic [ROW_W-1:0]  wr_row, rd_row;

  assign cfg_ok = (cfg_wdata[9:5] >= cfg_wdata[4:0]) &&
                  ({1'b0, cfg_wdata[14:10]} < 6'(NUM_BLK)) &&
                  (cfg_wdata[62:15] == '0);
  assign cfg_take = cfg_we && cfg_ok;

  assign rd_bank = rd_ptr[pop_qid][BANK_W-1:0];
  assign wr_bank = wr_ptr[push_qid][BANK_W-1:0];
  assign rd_row  = {q_blk[pop_qid],  rd_ptr[pop_qid][LOC_W-1:BANK_W]};
  assign wr_row  = {q_blk[push_qid], wr_ptr[push_qid][LOC_W-1:BANK_W]};

  assign pop_ok  = pop_valid && !(cfg_take && cfg_qid == pop_qid) && !q_empty[pop_qid];
  assign push_ok = push_valid && !(cfg_take && cfg_qid == push_qid) &&
                   q_en[push_qid] && !q_full[push_qid] &&
                   !(pop_ok && rd_bank == wr_bank);

  genvar g;
  generate
    for (g = 0; g < NUM_Q; g++) begin : gen_q
      logic inc, dec;
      assign inc = push_ok && push_qid == g;
      assign dec = pop_ok && pop_qid == g;
      assign cap[g] = CNT_W'({1'b0, q_last[g]} - {1'b0, q_first[g]} + 6'd1) << OFF_W;
      assign q_empty[g] = occ[g] == '0;
      assign q_full[g]  = occ[g] == cap[g];
      assign rd_nx[g] = (rd_ptr[g] == {q_last[g], {OFF_W{1'b1}}}) ?
                        {q_first[g], {OFF_W{1'b0}}} : rd_ptr[g] + 1'b1;
      assign wr_nx[g] = (wr_ptr[g] == {q_last[g], {OFF_W{1'b1}}}) ?
                        {q_first[g], {OFF_W{1'b0}}} : wr_ptr[g] + 1'b1;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q_en[g]    <= 1'b0;
          q_first[g] <= '0;
          q_last[g]  <= '0;
          q_blk[g]   <= '0;
          rd_ptr[g]  <= '0;
          wr_ptr[g]  <= '0;
          occ[g]     <= '0;
        end else if (cfg_take && cfg_qid == g) begin
          q_en[g]    <= cfg_wdata[63];
          q_first[g] <= cfg_wdata[4:0];
          q_last[g]  <= cfg_wdata[9:5];
          q_blk[g]   <= cfg_wdata[10 +: BLK_W];
          rd_ptr[g]  <= {cfg_wdata[4:0], {OFF_W{1'b0}}};
          wr_ptr[g]  <= {cfg_wdata[4:0], {OFF_W{1'b0}}};
          occ[g]     <= '0;
        end else begin
          if (inc) wr_ptr[g] <= wr_nx[g];
          if (dec) rd_ptr[g] <= rd_nx[g];
          occ[g] <= occ[g] + CNT_W'(inc) - CNT_W'(dec);
        end
      end
    end

    for (g = 0; g < BANKS; g++) begin : gen_bank
      logic [DATA_W-1:0] mem [ROWS];
      always_ff @(posedge clk) begin
        if (push_ok && wr_bank == g) mem[wr_row] <= push_data;
        if (pop_ok && rd_bank == g) bank_q[g] <= mem[rd_row];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pop_rvalid <= 1'b0;
      sel_bank   <= '0;
      err        <= 1'b0;
    end else begin
      pop_rvalid <= pop_ok;
      sel_bank   <= rd_bank;
      err        <= (push_valid && !push_ok) || (pop_valid && !pop_ok) ||
                    (cfg_we && !cfg_ok);
    end
  end

  assign pop_rdata = bank_q[sel_bank];
endmodule

// File: rtl/seg_queue_ring_chk.sv
module seg_queue_ring_chk #(
  parameter int NUM_Q = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_we,
  input logic                     push_valid,
  input logic [$clog2(NUM_Q)-1:0] push_qid,
  input logic                     pop_valid,
  input logic [$clog2(NUM_Q)-1:0] pop_qid,
  input logic                     pop_rvalid,
  input logic [NUM_Q-1:0]         q_empty,
  input logic [NUM_Q-1:0]         q_full,
  input logic                     err
);
  p_not_empty_and_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty & q_full) == '0);

  p_rvalid_needs_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_rvalid |-> $past(pop_valid));

  p_pop_empty_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && q_empty[pop_qid]) |=> err);

  p_push_full_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && q_full[push_qid]) |=> err);

  p_quiet_no_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_valid && !pop_valid && !cfg_we) |=> !err);

  p_no_rvalid_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && q_empty[pop_qid]) |=> !pop_rvalid);
endmodule

bind seg_queue_ring seg_queue_ring_chk #(.NUM_Q(NUM_Q)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
  .push_valid(push_valid), .push_qid(push_qid),
  .pop_valid(pop_valid), .pop_qid(pop_qid),
  .pop_rvalid(pop_rvalid), .q_empty(q_empty), .q_full(q_full), .err(err)
);

// File: tb/seg_queue_ring_bench.sv
module seg_queue_ring_bench;
  localparam int NQ = 4;
  localparam int NB = 2;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, cfg_we, push_valid, pop_valid;
  logic [1:0]    cfg_qid, push_qid, pop_qid;
  logic [63:0]   cfg_wdata;
  logic [DW-1:0] push_data, pop_rdata;
  logic          pop_rvalid, err;
  logic [NQ-1:0] q_empty, q_full;

  seg_queue_ring #(.NUM_Q(NQ), .NUM_BLK(NB), .DATA_W(DW)) u_seg_queue_ring (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_qid(cfg_qid),
    .cfg_wdata(cfg_wdata), .push_valid(push_valid), .push_qid(push_qid),
    .push_data(push_data), .pop_valid(pop_valid), .pop_qid(pop_qid),
    .pop_rvalid(pop_rvalid), .pop_rdata(pop_rdata),
    .q_empty(q_empty), .q_full(q_full), .err(err)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int m_en[NQ], m_s[NQ], m_e[NQ], m_head[NQ], m_tail[NQ], m_cnt[NQ];
  logic [DW-1:0] mdat [NQ][$];

  function automatic int cap(int q);
    return (m_e[q] - m_s[q] + 1) * 32;
  endfunction

  function automatic int bump(int q, int p);
    return (p == m_e[q] * 32 + 31) ? m_s[q] * 32 : p + 1;
  endfunction

  function automatic logic [63:0] word(bit en, int s, int e, int b);
    logic [4:0] s5, e5, b5;
    s5 = 5'(s); e5 = 5'(e); b5 = 5'(b);
    return {en, 48'd0, b5, e5, s5};
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit pv, int pq, logic [DW-1:0] pd, bit ov, int oq,
                      bit cw, int cq, logic [63:0] cd, string tag);
    bit cvalid, pop_ok, push_ok, e_err;
    logic [DW-1:0] e_rd;
    logic [NQ-1:0] e_em, e_fu;
    push_valid = pv; push_qid = 2'(pq); push_data = pd;
    pop_valid = ov; pop_qid = 2'(oq);
    cfg_we = cw; cfg_qid = 2'(cq); cfg_wdata = cd;
    cvalid = cw && (cd[9:5] >= cd[4:0]) && (int'(cd[14:10]) < NB) && (cd[62:15] == '0);
    pop_ok = ov && !(cvalid && cq == oq) && m_cnt[oq] != 0;
    push_ok = pv && !(cvalid && cq == pq) && m_en[pq] != 0 && m_cnt[pq] != cap(pq) &&
              !(pop_ok && (m_head[oq] % 8) == (m_tail[pq] % 8));
    e_err = (pv && !push_ok) || (ov && !pop_ok) || (cw && !cvalid);
    e_rd = '0;
    if (pop_ok) begin
      e_rd = mdat[oq].pop_front();
      m_head[oq] = bump(oq, m_head[oq]);
      m_cnt[oq]--;
    end
    if (push_ok) begin
      mdat[pq].push_back(pd);
      m_tail[pq] = bump(pq, m_tail[pq]);
      m_cnt[pq]++;
    end
    if (cvalid) begin
      m_en[cq] = int'(cd[63]); m_s[cq] = int'(cd[4:0]); m_e[cq] = int'(cd[9:5]);
      m_head[cq] = m_s[cq] * 32; m_tail[cq] = m_s[cq] * 32; m_cnt[cq] = 0;
      mdat[cq].delete();
    end
    for (int q = 0; q < NQ; q++) begin
      e_em[q] = m_cnt[q] == 0;
      e_fu[q] = m_cnt[q] == cap(q);
    end
    @(posedge clk);
    @(negedge clk);
    chk(err == e_err, tag, "err", longint'(err), longint'(e_err));
    chk(pop_rvalid == pop_ok, tag, "pop_rvalid", longint'(pop_rvalid), longint'(pop_ok));
    if (pop_ok) chk(pop_rdata == e_rd, tag, "pop_rdata", longint'(pop_rdata), longint'(e_rd));
    chk(q_empty == e_em, tag, "q_empty", longint'(q_empty), longint'(e_em));
    chk(q_full == e_fu, tag, "q_full", longint'(q_full), longint'(e_fu));
  endtask

  task automatic psh(int q, logic [DW-1:0] d, string tag);
    step(1, q, d, 0, 0, 0, 0, '0, tag);
  endtask
  task automatic pp(int q, string tag);
    step(0, 0, '0, 1, q, 0, 0, '0, tag);
  endtask
  task automatic cfg(int q, logic [63:0] w, string tag);
    step(0, 0, '0, 0, 0, 1, q, w, tag);
  endtask

  function automatic logic [63:0] region(int q, bit en);
    case (q)
      0: return word(en, 0, 0, 0);
      1: return word(en, 1, 2, 0);
      2: return word(en, 0, 0, 1);
      default: return word(en, 31, 31, 1);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int q = 0; q < NQ; q++) begin
      m_en[q] = 0; m_s[q] = 0; m_e[q] = 0; m_head[q] = 0; m_tail[q] = 0; m_cnt[q] = 0;
    end
    rst_n = 0; cfg_we = 0; cfg_qid = 0; cfg_wdata = '0;
    push_valid = 0; push_qid = 0; push_data = '0; pop_valid = 0; pop_qid = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(q_empty == '1, "R1", "q_empty", longint'(q_empty), 64'hF);
    chk(q_full == '0, "R1", "q_full", longint'(q_full), 0);
    chk(err == 1'b0, "R1", "err", longint'(err), 0);
    chk(pop_rvalid == 1'b0, "R1", "pop_rvalid", longint'(pop_rvalid), 0);

    // R2 configuration
    for (int q = 0; q < 3; q++) cfg(q, region(q, 1), "R2");
    cfg(3, region(3, 0), "R2");

    // R6 disabled push, empty pop
    psh(3, 16'h3333, "R6");
    pp(2, "R6");

    // R11 rejected configurations keep state
    psh(1, 16'h1100, "R11");
    psh(1, 16'h1101, "R11");
    cfg(1, word(1, 3, 2, 0), "R11");
    cfg(1, word(1, 0, 0, 2), "R11");
    cfg(1, word(1, 1, 2, 0) | (64'd1 << 40), "R11");
    step(1, 1, 16'h1102, 0, 0, 1, 1, word(1, 5, 4, 0), "R11");

    // R4 fill to full, R6 overflow, R3 drain
    for (int i = 0; i < 32; i++) psh(0, 16'h0A00 + 16'(i), "R4");
    psh(0, 16'hDEAD, "R6");
    for (int i = 0; i < 32; i++) pp(0, "R3");
    pp(0, "R6");

    // R7 same-queue push and pop with differing banks
    for (int i = 0; i < 6; i++) step(1, 1, 16'h7700 + 16'(i), 1, 1, 0, 0, '0, "R7");

    // R8 same-bank clash: q2 with 8 entries
    for (int i = 0; i < 8; i++) psh(2, 16'h2200 + 16'(i), "R8");
    step(1, 2, 16'h22FF, 1, 2, 0, 0, '0, "R8");
    psh(0, 16'h0B00, "R8");
    step(1, 0, 16'h0B01, 1, 2, 0, 0, '0, "R8");

    // R9 configuration beats push and pop
    step(1, 1, 16'h9999, 0, 0, 1, 1, region(1, 1), "R9");
    step(0, 0, '0, 1, 2, 1, 2, region(2, 1), "R9");
    pp(0, "R9");

    // R10 isolation between blocks and segments
    for (int i = 0; i < 6; i++) begin
      psh(0, 16'hA000 + 16'(i), "R10");
      psh(2, 16'hB000 + 16'(i), "R10");
      psh(1, 16'hC000 + 16'(i), "R10");
    end
    for (int i = 0; i < 6; i++) begin
      pp(2, "R10"); pp(0, "R10"); pp(1, "R10");
    end

    // R5 wrap in the top segment and across a two-segment region
    cfg(3, region(3, 1), "R5");
    for (int i = 0; i < 80; i++) begin
      psh(3, 16'h5000 + 16'(i), "R5");
      if (i % 3 != 0) pp(3, "R5");
    end
    for (int i = 0; i < 150; i++) begin
      psh(1, 16'h6000 + 16'(i), "R5");
      pp(1, "R5");
    end

    // Mixed sweep over all queues
    r = 32'h1234_5678;
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] w;
      r ^= r << 13; r ^= r >> 17; r ^= r << 5;
      w = region(int'(r[17:16]), r[18] | r[19]);
      if (r[23:20] == 0) w = word(1, 4, 3, 0);
      step(r[0] | r[5], int'(r[3:2]), r[31:16], r[1] | r[6], int'(r[8:7]),
           r[15:10] == 0, int'(r[17:16]), w, "R3");
    end

    step(0, 0, '0, 0, 0, 0, 0, '0, "R6");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule